// File: doc/BRIEF.md
# Capture/Compare Timer with Pulse Accumulator

This block is a timer for peripheral use. A 16-bit free-running counter advances once every 2^s enabled clock cycles, where s comes from a power-of-two prescaler. A new prescale choice does not take effect mid-period. It is held back until every stage of the prescaler is zero.

Eight channels share the counter. Each channel is either an input capture unit or an output compare unit. A capture unit latches the count on a selected pin edge. A compare unit acts on its output pin when the count reaches its register value. Channel 7 can also force the outputs of any masked compare channels to fixed levels. A separate 16-bit pulse accumulator counts edges on its own pin.

Software reaches all state through a word-wide register port. Read data is combinational from the address. Writes take effect on the clock edge that samples the write enable. Event flags feed one interrupt request, gated by a mask.

Top module: `cc_timer`

## Requirements
- R1: The counter (address 0, read-only) resets to 0. It holds while the enable bit CTRL[0] (address 1) is 0. With prescale select s = CTRL[3:1], after M enabled cycles that start with the prescaler at zero, the counter reads floor(M / 2^s).
- R2: A newly written prescale select takes effect only in a cycle where the 7-bit prescale counter is zero. Until then, the previous select keeps governing the count rate.
- R3: Address 2 bit k set puts channel k in compare mode. Its action field at address 3, bits [2k+1:2k], selects what happens when the counter steps onto the channel value: 00 no pin change, 01 toggle, 10 drive low, 11 drive high. The pin changes in the same cycle the counter reaches the value, and flag k is set.
- R4: Address 4 holds a mask in bits [7:0] and a data pattern in bits [15:8]. When channel 7 matches in compare mode, every compare channel k whose mask bit is set drives its pin to data bit k. This takes precedence over that channel's own action in the same cycle.
- R5: In capture mode (address 2 bit k = 0), the action field selects the edge: 00 none, 01 rising, 10 falling, 11 both. On a selected edge, the channel register (address 8+k) loads the count present before that clock edge, and flag k is set.
- R6: The flag register (address 6) clears a bit only when 1 is written to that bit. Writing 0 leaves the bit unchanged.
- R7: irq_o is high exactly when some flag bit is set and the matching bit of the mask register (address 5) is also set.
- R8: When the counter steps from 0xFFFF to 0x0000, flag bit 8 is set.
- R9: The pulse accumulator (address 7) counts edges on pa_i only while CTRL[4] is 1. It counts rising edges when CTRL[5] is 1 and falling edges when CTRL[5] is 0. Edges are ignored while CTRL[4] is 0.
- R10: The accumulator is writable. When it steps from 0xFFFF to 0x0000, flag bit 9 is set.
- R11: After reset, all registers, flags, compare pins and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cap_i | input | 8 | Capture pins, one per channel |
| pa_i | input | 1 | Pulse accumulator pin |
| cmp_o | output | 8 | Compare pins, one per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The deferred prescale change is the hardest case to reach from the ports. The stimulus starts the counter at a divide-by-4 rate and switches to divide-by-1 ten cycles in. It then checks the count before and after the prescale counter wraps through zero, about 118 cycles later. The channel 7 override needs a compare match on a masked channel in the same cycle as a channel 7 match. The stimulus gives both channels the same compare value and opposing actions. Counter overflow is reached by letting the undivided counter run through all 65536 states.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;

  localparam int A_CNT  = 0;
  localparam int A_CTRL = 1;
  localparam int A_DIR  = 2;
  localparam int A_MODE = 3;
  localparam int A_OVR  = 4;
  localparam int A_MASK = 5;
  localparam int A_FLAG = 6;
  localparam int A_ACC  = 7;
  localparam int A_CH0  = 8;
endpackage

// File: rtl/cct_prescale.sv
module cct_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, msk;
  logic [SEL_W-1:0] sel_q, sel_eff;

  // requested select is only honoured when all stages read zero
  always_comb begin
    sel_eff = (pre_q == '0) ? sel_i : sel_q;
    for (int i = 0; i < PRE_W; i++) msk[i] = (i < int'(sel_eff));
  end

  assign tick_o = en_i && ((pre_q & msk) == msk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sel_q <= '0;
    end else begin
      if (en_i) pre_q <= pre_q + 1'b1;
      if (pre_q == '0) sel_q <= sel_i;
    end
  end

  p_defer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_q != '0) |=> (sel_q == $past(sel_q)));
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             is_cmp_i,
  input  logic [1:0]       act_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             pin_i,
  input  logic             ovr_i,
  input  logic             ovr_val_i,
  output logic [CNT_W-1:0] val_o,
  output logic             out_o,
  output logic             match_o,
  output logic             cap_o
);
  logic [CNT_W-1:0] val_q;
  logic             pin_q, out_q;
  logic             rise, fall;

  assign rise    = pin_i & ~pin_q;
  assign fall    = ~pin_i & pin_q;
  assign match_o = is_cmp_i && tick_i && (cnt_nxt_i == val_q);
  assign cap_o   = !is_cmp_i && ((act_i[0] && rise) || (act_i[1] && fall));
  assign val_o   = val_q;
  assign out_o   = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      pin_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (wr_i)       val_q <= wdata_i;
      else if (cap_o) val_q <= cnt_i;
      if (ovr_i) out_q <= ovr_val_i;
      else if (match_o) begin
        case (cmp_act_e'(act_i))
          ACT_TOGGLE: out_q <= ~out_q;
          ACT_CLEAR:  out_q <= 1'b0;
          ACT_SET:    out_q <= 1'b1;
          default:    out_q <= out_q;
        endcase
      end
    end
  end

  p_override_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> (out_q == $past(ovr_val_i)));
  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && !wr_i) |=> (val_q == $past(cnt_i)));
  p_set_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !ovr_i && act_i == 2'b11) |=> out_q);
endmodule

// File: rtl/cct_pulse_acc.sv
module cct_pulse_acc #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_sel_i,
  input  logic             pin_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] acc_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] acc_q;
  logic             pin_q, edge_hit, step;

  assign edge_hit = rise_sel_i ? (pin_i & ~pin_q) : (~pin_i & pin_q);
  assign step     = en_i && edge_hit && !wr_i;
  assign ovf_o    = step && (acc_q == '1);
  assign acc_o    = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (wr_i)      acc_q <= wdata_i;
      else if (step) acc_q <= acc_q + 1'b1;
    end
  end

  p_acc_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (acc_q == '0));
  p_acc_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> $stable(acc_q));
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [N_CH-1:0]   cap_i,
  input  logic              pa_i,
  output logic [N_CH-1:0]   cmp_o,
  output logic              irq_o
);
  localparam int FL_W   = N_CH + 2;
  localparam int MODE_W = 2 * N_CH;
  localparam int CTRL_W = SEL_W + 3;
  localparam int B_AEN  = SEL_W + 1;
  localparam int B_ARIS = SEL_W + 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [N_CH-1:0]   dir_q, ovr_msk_q, ovr_dat_q;
  logic [MODE_W-1:0] mode_q;
  logic [FL_W-1:0]   mask_q, flag_q, flag_set, flag_clr;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, acc;
  logic              tick, acc_ovf, cnt_ovf;

  logic [CNT_W-1:0]  ch_val [N_CH];
  logic [N_CH-1:0]   ch_match, ch_cap, ch_ovr, ch_wr;

  function automatic logic hit(input int a);
    return wr_en_i && (addr_i == ADDR_W'(a));
  endfunction

  cct_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q[0]),
    .sel_i  (ctrl_q[SEL_W:1]),
    .tick_o (tick)
  );

  assign cnt_nxt = cnt_q + 1'b1;
  assign cnt_ovf = tick && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign ch_wr[k]  = hit(A_CH0 + k);
    assign ch_ovr[k] = ch_match[N_CH-1] && ovr_msk_q[k] && dir_q[k];

    cct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .is_cmp_i  (dir_q[k]),
      .act_i     (mode_q[2*k+1:2*k]),
      .cnt_i     (cnt_q),
      .cnt_nxt_i (cnt_nxt),
      .tick_i    (tick),
      .wr_i      (ch_wr[k]),
      .wdata_i   (wdata_i),
      .pin_i     (cap_i[k]),
      .ovr_i     (ch_ovr[k]),
      .ovr_val_i (ovr_dat_q[k]),
      .val_o     (ch_val[k]),
      .out_o     (cmp_o[k]),
      .match_o   (ch_match[k]),
      .cap_o     (ch_cap[k])
    );
  end

  cct_pulse_acc #(.CNT_W(CNT_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q[B_AEN]),
    .rise_sel_i (ctrl_q[B_ARIS]),
    .pin_i      (pa_i),
    .wr_i       (hit(A_ACC)),
    .wdata_i    (wdata_i),
    .acc_o      (acc),
    .ovf_o      (acc_ovf)
  );

  assign flag_set = {acc_ovf, cnt_ovf, ch_match | ch_cap};
  assign flag_clr = hit(A_FLAG) ? wdata_i[FL_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      dir_q     <= '0;
      mode_q    <= '0;
      ovr_msk_q <= '0;
      ovr_dat_q <= '0;
      mask_q    <= '0;
      flag_q    <= '0;
    end else begin
      if (hit(A_CTRL)) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (hit(A_DIR))  dir_q  <= wdata_i[N_CH-1:0];
      if (hit(A_MODE)) mode_q <= wdata_i[MODE_W-1:0];
      if (hit(A_OVR)) begin
        ovr_msk_q <= wdata_i[N_CH-1:0];
        ovr_dat_q <= wdata_i[2*N_CH-1:N_CH];
      end
      if (hit(A_MASK)) mask_q <= wdata_i[FL_W-1:0];
      // a new event wins over a same-cycle clear
      flag_q <= (flag_q & ~flag_clr) | flag_set;
    end
  end

  assign irq_o = |(flag_q & mask_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_CNT):  rdata_o = cnt_q;
      ADDR_W'(A_CTRL): rdata_o = CNT_W'(ctrl_q);
      ADDR_W'(A_DIR):  rdata_o = CNT_W'(dir_q);
      ADDR_W'(A_MODE): rdata_o = CNT_W'(mode_q);
      ADDR_W'(A_OVR):  rdata_o = CNT_W'({ovr_dat_q, ovr_msk_q});
      ADDR_W'(A_MASK): rdata_o = CNT_W'(mask_q);
      ADDR_W'(A_FLAG): rdata_o = CNT_W'(flag_q);
      ADDR_W'(A_ACC):  rdata_o = acc;
      default: begin
        for (int k = 0; k < N_CH; k++)
          if (addr_i == ADDR_W'(A_CH0 + k)) rdata_o = ch_val[k];
      end
    endcase
  end

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_cnt_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[0] |=> $stable(cnt_q));
  p_wrap_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q == '1) |=> flag_q[N_CH]);
  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit(A_FLAG) && flag_set == '0) |=> ((flag_q & $past(wdata_i[FL_W-1:0])) == '0));
  p_flag_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit(A_FLAG)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/tb_cc_timer.sv
module tb_cc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  cap = '0;
  logic        pa = 1'b0;
  logic [7:0]  cmp;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cc_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .pa_i(pa),
    .cmp_o(cmp), .irq_o(irq)
  );

  // prescaler vectors: select, enabled cycles, expected count
  localparam int NV = 6;
  localparam int PS_SEL [NV] = '{0, 1, 2, 3, 5, 7};
  localparam int PS_CYC [NV] = '{5, 9, 10, 40, 100, 300};
  localparam int PS_EXP [NV] = '{5, 4, 2, 5, 3, 2};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; cap = '0; pa = 1'b0; addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse();
    pa = 1'b1; @(negedge clk);
    pa = 1'b0; @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    @(negedge clk);
    do_reset();

    // R11 reset state
    rd(4'd0, v); chk("R11 count", v, 0);
    rd(4'd1, v); chk("R11 ctrl", v, 0);
    rd(4'd6, v); chk("R11 flags", v, 0);
    chk("R11 cmp pins", cmp, 0);
    chk("R11 irq", irq, 0);

    // R1 prescaler table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(4'd1, 16'(1 | (PS_SEL[i] << 1)));
      repeat (PS_CYC[i]) @(negedge clk);
      rd(4'd0, v);
      chk($sformatf("R1 vector %0d", i), v, 32'(PS_EXP[i]));
    end

    // R2 deferred prescale change: divide by 4, then switch to 1
    do_reset();
    wr(4'd1, 16'h0005);
    repeat (10) @(negedge clk);
    rd(4'd0, v); chk("R2 before change", v, 2);
    wr(4'd1, 16'h0001);
    repeat (9) @(negedge clk);
    rd(4'd0, v); chk("R2 old rate kept", v, 5);
    repeat (108) @(negedge clk);
    rd(4'd0, v); chk("R2 at wrap", v, 32);
    repeat (2) @(negedge clk);
    rd(4'd0, v); chk("R2 new rate", v, 34);

    // R3/R4 compare actions and channel 7 override
    do_reset();
    wr(4'd2, 16'h008F);
    wr(4'd3, 16'h001B);
    wr(4'd8, 16'd5);
    wr(4'd9, 16'd7);
    wr(4'd10, 16'd3);
    wr(4'd11, 16'd3);
    wr(4'd15, 16'd7);
    wr(4'd4, 16'h0203);
    wr(4'd1, 16'h0001);
    repeat (2) @(negedge clk);
    chk("R3 toggle not yet", cmp[2], 0);
    @(negedge clk);
    chk("R3 toggle at match", cmp[2], 1);
    chk("R3 no-change action", cmp[3], 0);
    rd(4'd6, v); chk("R3 flags ch2 ch3", v, 16'h000C);
    repeat (2) @(negedge clk);
    chk("R3 set at match", cmp[1:0], 2'b01);
    repeat (2) @(negedge clk);
    chk("R4 override pins", cmp[1:0], 2'b10);
    chk("R4 ch7 own pin", cmp[7], 0);
    rd(4'd6, v); chk("R3 compare flags", v, 16'h008F);

    // R7 interrupt gating, R6 write-one-to-clear
    chk("R7 masked irq", irq, 0);
    wr(4'd5, 16'h0080);
    chk("R7 unmasked irq", irq, 1);
    wr(4'd6, 16'h0001);
    rd(4'd6, v); chk("R6 clear one bit", v, 16'h008E);
    wr(4'd6, 16'h0000);
    rd(4'd6, v); chk("R6 zero write", v, 16'h008E);
    wr(4'd6, 16'h0080);
    chk("R7 irq drops", irq, 0);

    // R5 input capture edges
    do_reset();
    wr(4'd3, 16'h3900);
    wr(4'd1, 16'h0001);
    repeat (3) @(negedge clk);
    cap = 8'hF0;
    repeat (2) @(negedge clk);
    cap = 8'h00;
    @(negedge clk);
    rd(4'd12, v); chk("R5 rising", v, 3);
    rd(4'd13, v); chk("R5 falling", v, 5);
    rd(4'd14, v); chk("R5 both", v, 5);
    rd(4'd15, v); chk("R5 disabled", v, 0);
    rd(4'd6, v);  chk("R5 flags", v, 16'h0070);

    // R9/R10 pulse accumulator
    do_reset();
    wr(4'd1, 16'h0030);
    repeat (3) pulse();
    rd(4'd7, v); chk("R9 rising count", v, 3);
    wr(4'd1, 16'h0010);
    repeat (2) pulse();
    rd(4'd7, v); chk("R9 falling count", v, 5);
    wr(4'd1, 16'h0000);
    repeat (2) pulse();
    rd(4'd7, v); chk("R9 disabled ignores", v, 5);
    rd(4'd0, v); chk("R1 timer held", v, 0);
    wr(4'd7, 16'hFFFF);
    wr(4'd1, 16'h0030);
    pulse();
    rd(4'd7, v); chk("R10 wrap", v, 0);
    rd(4'd6, v); chk("R10 flag", v, 16'h0200);

    // R8 counter overflow
    do_reset();
    wr(4'd5, 16'h0100);
    wr(4'd1, 16'h0001);
    repeat (65535) @(negedge clk);
    rd(4'd0, v); chk("R8 top count", v, 16'hFFFF);
    chk("R8 no irq yet", irq, 0);
    @(negedge clk);
    rd(4'd0, v); chk("R8 wrapped", v, 0);
    rd(4'd6, v); chk("R8 flag", v, 16'h0100);
    chk("R7 overflow irq", irq, 1);
    wr(4'd6, 16'h0000);
    rd(4'd6, v); chk("R6 zero keeps overflow", v, 16'h0100);
    wr(4'd6, 16'h0100);
    rd(4'd6, v); chk("R6 overflow cleared", v, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule